// File: doc/BRIEF.md
# Refresh and Self-Refresh Sequencer

This block sits beside the main command scheduler of a simple DRAM controller and takes over the command bus whenever the memory needs maintenance. An internal interval timer raises a refresh need at a fixed period. When the scheduler grants the bus, the sequencer closes all banks with one precharge-all command, waits the row-precharge time, issues REFRESH, and keeps the bus for the refresh-cycle time before handing it back.

A sleep request makes the sequencer put the memory into self refresh. It closes the banks the same way, then issues the refresh command code while dropping the clock-enable line in the same cycle. A modelled DLL-enable status goes low at that point with no mode-register access. A wake request raises clock enable and the DLL status again. The bus is held for the refresh-cycle time after that, and then released.

Only one missed refresh is remembered. If a refresh and a sleep are both waiting, the refresh is done first.

Top module: `refresh_sequencer`

## Requirements
- R1: While reset is asserted, and after it, until work arrives, the outputs are: `cke`=1, `dll_en`=1, `busy`=0, `bus_req`=0, `cmd`=NOP, `addr`=0. Asserting reset at any time, including during self refresh, returns them to these values at once.
- R2: Command codes on `cmd` are NOP=0, PRECHARGE=1 and REFRESH=2. A PRECHARGE drives `addr` with only bit `PALL_BIT` (default 10) set, which selects all banks. A REFRESH drives `addr` to all zeros.
- R3: With `bus_gnt` held high and no sleep request, REFRESH commands appear exactly `REF_INTERVAL` cycles apart.
- R4: `bus_req` is high in the idle state while a refresh or sleep is waiting. Until `bus_gnt` is seen together with `bus_req`, `busy` stays low and `cmd` stays NOP. The cycle after the grant, `busy` rises and PRECHARGE appears.
- R5: Every REFRESH (auto or self-refresh entry) comes exactly `T_RP` cycles after the precharge-all that precedes it.
- R6: After an auto REFRESH, `busy` falls exactly `T_RFC` cycles after the REFRESH cycle.
- R7: However many refresh periods pass without a grant, one grant yields exactly one REFRESH, after which `bus_req` is low.
- R8: When a refresh and a sleep request are both waiting, the first REFRESH issued has `cke`=1. The self-refresh entry follows in a later sequence.
- R9: Self-refresh entry is a REFRESH code with `cke`=0 in the same cycle, and `dll_en` goes low in that cycle.
- R10: In self refresh, `cke` stays 0, `cmd` stays NOP and `busy` stays 1, whatever `sleep_req` does. The cycle after `wake_req` is sampled high, `cke` and `dll_en` return to 1, and `busy` falls exactly `T_RFC` cycles after that.
- R11: `wake_req` outside self refresh has no effect on `cke`, `busy` or `bus_req`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| sleep_req | input | 1 | Level request to enter self refresh |
| wake_req | input | 1 | Request to leave self refresh |
| bus_gnt | input | 1 | Scheduler hands the command bus to the sequencer |
| bus_req | output | 1 | Sequencer asks for the command bus |
| busy | output | 1 | Sequencer owns the command bus |
| cmd | output | 3 | Command code (NOP=0, PRECHARGE=1, REFRESH=2) |
| cke | output | 1 | Clock-enable level toward the memory |
| addr | output | ADDR_W | Address bus |
| dll_en | output | 1 | Modelled DLL-enable status |

## Verification
The assertions assume the scheduler grants only while `bus_req` is high. They assume `T_RP` and `T_RFC` are at least two, and that `REF_INTERVAL` is longer than one full precharge-refresh-recovery sequence, so that timer ticks never overlap a sequence. They also assume `sleep_req` is held until the entry REFRESH appears. The stimulus grants only after seeing `bus_req`, uses an interval of 40 cycles against a sequence of under ten, holds `sleep_req` through entry, and pulses `wake_req` only in self refresh, except for the one directed case that shows it being ignored.

// File: rtl/rfsh_pkg.sv
package rfsh_pkg;

  typedef enum logic [2:0] {
    CMD_NOP = 3'd0,
    CMD_PRE = 3'd1,
    CMD_REF = 3'd2
  } cmd_e;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_PRE_ALL,
    ST_WAIT_RP,
    ST_REF,
    ST_WAIT_RFC,
    ST_SR_ENTER,
    ST_SR_HOLD,
    ST_SR_EXIT
  } state_e;

endpackage

// File: rtl/rfsh_interval_timer.sv
// Free-running down counter that pulses once per period while enabled.
module rfsh_interval_timer #(
  parameter int INTERVAL = 7800
) (
  input  logic clk,
  input  logic rst_n,
  input  logic run,
  output logic tick
);
  localparam int TW = $clog2(INTERVAL);
  localparam logic [TW-1:0] RELOAD = TW'(INTERVAL - 1);

  logic [TW-1:0] cnt_q, cnt_d;

  always_comb begin
    tick = run && (cnt_q == '0);
    if (!run || cnt_q == '0) cnt_d = RELOAD;
    else                     cnt_d = cnt_q - 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cnt_q <= RELOAD;
    else        cnt_q <= cnt_d;
  end
endmodule

// File: rtl/rfsh_wait_counter.sv
// Loadable down counter; done while it rests at zero.
module rfsh_wait_counter #(
  parameter int CW = 4
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          load,
  input  logic [CW-1:0] load_val,
  output logic          done
);
  logic [CW-1:0] cnt_q, cnt_d;
  logic          cnt_en;

  always_comb begin
    cnt_en = load || (cnt_q != '0);
    cnt_d  = load ? load_val : cnt_q - 1'b1;
    done   = (cnt_q == '0);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      cnt_q <= '0;
    else if (cnt_en) cnt_q <= cnt_d;
  end
endmodule

// File: rtl/rfsh_fsm.sv
// Sequencing state machine with registered command outputs.
module rfsh_fsm
  import rfsh_pkg::*;
#(
  parameter int T_RP     = 4,
  parameter int T_RFC    = 44,
  parameter int ADDR_W   = 14,
  parameter int PALL_BIT = 10,
  parameter int CW       = 6
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              tick,
  input  logic              sleep_req,
  input  logic              wake_req,
  input  logic              bus_gnt,
  input  logic              wait_done,
  output logic              wait_load,
  output logic [CW-1:0]     wait_val,
  output logic              timer_run,
  output logic              bus_req,
  output logic              busy,
  output logic [2:0]        cmd,
  output logic              cke,
  output logic [ADDR_W-1:0] addr,
  output logic              dll_en
);
  localparam logic [ADDR_W-1:0] PALL_ADDR = ADDR_W'(1) << PALL_BIT;
  localparam logic [CW-1:0]     RP_LOAD   = CW'(T_RP - 2);
  localparam logic [CW-1:0]     RFC_LOAD  = CW'(T_RFC - 2);

  state_e state_q, state_d;
  logic   pend_q, pend_d;

  cmd_e              cmd_d;
  logic              cke_d, busy_d, dll_d;
  logic [ADDR_W-1:0] addr_d;
  logic [2:0]        cmd_q;
  logic              cke_q, busy_q, dll_q;
  logic [ADDR_W-1:0] addr_q;

  // Pending refresh: one slot, set by the timer, cleared when served.
  always_comb begin
    pend_d = tick || (pend_q && (state_q != ST_REF));
  end

  always_comb begin
    bus_req   = (state_q == ST_IDLE) && (pend_q || sleep_req);
    timer_run = !(state_q inside {ST_SR_ENTER, ST_SR_HOLD, ST_SR_EXIT});
    wait_load = state_q inside {ST_PRE_ALL, ST_REF, ST_SR_EXIT};
    wait_val  = (state_q == ST_PRE_ALL) ? RP_LOAD : RFC_LOAD;
  end

  // Next-state logic.
  always_comb begin
    state_d = state_q;
    unique case (state_q)
      ST_IDLE:     if (bus_req && bus_gnt) state_d = ST_PRE_ALL;
      ST_PRE_ALL:  state_d = ST_WAIT_RP;
      ST_WAIT_RP:  if (wait_done) begin
                     if (pend_q)         state_d = ST_REF;
                     else if (sleep_req) state_d = ST_SR_ENTER;
                     else                state_d = ST_IDLE;
                   end
      ST_REF:      state_d = ST_WAIT_RFC;
      ST_WAIT_RFC: if (wait_done) state_d = ST_IDLE;
      ST_SR_ENTER: state_d = ST_SR_HOLD;
      ST_SR_HOLD:  if (wake_req) state_d = ST_SR_EXIT;
      ST_SR_EXIT:  state_d = ST_WAIT_RFC;
      default:     state_d = ST_IDLE;
    endcase
  end

  // Output decode of the next state, registered below.
  always_comb begin
    cmd_d  = CMD_NOP;
    addr_d = '0;
    if (state_d == ST_PRE_ALL) begin
      cmd_d  = CMD_PRE;
      addr_d = PALL_ADDR;
    end else if (state_d inside {ST_REF, ST_SR_ENTER}) begin
      cmd_d  = CMD_REF;
    end
    cke_d  = !(state_d inside {ST_SR_ENTER, ST_SR_HOLD});
    dll_d  = !(state_d inside {ST_SR_ENTER, ST_SR_HOLD});
    busy_d = (state_d != ST_IDLE);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= ST_IDLE;
      pend_q  <= 1'b0;
    end else begin
      state_q <= state_d;
      pend_q  <= pend_d;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cmd_q  <= CMD_NOP;
      addr_q <= '0;
      cke_q  <= 1'b1;
      dll_q  <= 1'b1;
      busy_q <= 1'b0;
    end else begin
      cmd_q  <= cmd_d;
      addr_q <= addr_d;
      cke_q  <= cke_d;
      dll_q  <= dll_d;
      busy_q <= busy_d;
    end
  end

  assign cmd    = cmd_q;
  assign addr   = addr_q;
  assign cke    = cke_q;
  assign dll_en = dll_q;
  assign busy   = busy_q;
endmodule

// File: rtl/refresh_sequencer.sv
module refresh_sequencer #(
  parameter int REF_INTERVAL = 7800,
  parameter int T_RP         = 4,
  parameter int T_RFC        = 44,
  parameter int ADDR_W       = 14,
  parameter int PALL_BIT     = 10
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              sleep_req,
  input  logic              wake_req,
  input  logic              bus_gnt,
  output logic              bus_req,
  output logic              busy,
  output logic [2:0]        cmd,
  output logic              cke,
  output logic [ADDR_W-1:0] addr,
  output logic              dll_en
);
  localparam int WAIT_MAX = (T_RP > T_RFC) ? T_RP : T_RFC;
  localparam int CW       = $clog2(WAIT_MAX + 1);

  logic [1:0]    rst_pipe;
  logic          rst_n_int;
  logic          tick, timer_run, wait_load, wait_done;
  logic [CW-1:0] wait_val;

  // Asynchronous assertion, synchronous release.
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_pipe <= 2'b00;
    else        rst_pipe <= {rst_pipe[0], 1'b1};
  end
  assign rst_n_int = rst_pipe[1] & rst_n;

  rfsh_interval_timer #(.INTERVAL(REF_INTERVAL)) u_timer (
    .clk   (clk),
    .rst_n (rst_n_int),
    .run   (timer_run),
    .tick  (tick)
  );

  rfsh_wait_counter #(.CW(CW)) u_wait (
    .clk      (clk),
    .rst_n    (rst_n_int),
    .load     (wait_load),
    .load_val (wait_val),
    .done     (wait_done)
  );

  rfsh_fsm #(
    .T_RP     (T_RP),
    .T_RFC    (T_RFC),
    .ADDR_W   (ADDR_W),
    .PALL_BIT (PALL_BIT),
    .CW       (CW)
  ) u_fsm (
    .clk       (clk),
    .rst_n     (rst_n_int),
    .tick      (tick),
    .sleep_req (sleep_req),
    .wake_req  (wake_req),
    .bus_gnt   (bus_gnt),
    .wait_done (wait_done),
    .wait_load (wait_load),
    .wait_val  (wait_val),
    .timer_run (timer_run),
    .bus_req   (bus_req),
    .busy      (busy),
    .cmd       (cmd),
    .cke       (cke),
    .addr      (addr),
    .dll_en    (dll_en)
  );
endmodule

// File: rtl/refresh_sequencer_chk.sv
module refresh_sequencer_chk #(
  parameter int T_RP     = 4,
  parameter int T_RFC    = 44,
  parameter int ADDR_W   = 14,
  parameter int PALL_BIT = 10
) (
  input logic              clk,
  input logic              rst_n,
  input logic              bus_gnt,
  input logic              bus_req,
  input logic              busy,
  input logic [2:0]        cmd,
  input logic              cke,
  input logic [ADDR_W-1:0] addr,
  input logic              dll_en
);
  localparam int PW = $clog2(T_RP + 1);
  localparam int RW = $clog2(T_RFC + 1);
  localparam logic [2:0] C_NOP = 3'd0;
  localparam logic [2:0] C_PRE = 3'd1;
  localparam logic [2:0] C_REF = 3'd2;
  localparam logic [ADDR_W-1:0] PALL_ADDR = ADDR_W'(1) << PALL_BIT;

  logic [PW-1:0] since_pre;
  logic [RW-1:0] since_ref;
  logic          cke_prev;

  // Cycles since the last precharge-all (0 = none since last REFRESH).
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                                    since_pre <= '0;
    else if (cmd == C_PRE)                         since_pre <= PW'(1);
    else if (cmd == C_REF)                         since_pre <= '0;
    else if (since_pre != '0 && since_pre < PW'(T_RP)) since_pre <= since_pre + 1'b1;
  end

  // Cycles since the last REFRESH or clock-enable rise.
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      since_ref <= '0;
      cke_prev  <= 1'b1;
    end else begin
      cke_prev <= cke;
      if (cmd == C_REF || (cke && !cke_prev)) since_ref <= RW'(1);
      else if (since_ref < RW'(T_RFC))         since_ref <= since_ref + 1'b1;
    end
  end

  a_r2_ref_addr_zero: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd == C_REF) |-> (addr == '0));
  a_r2_pre_all_addr: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd == C_PRE) |-> (addr == PALL_ADDR));
  a_r4_quiet_when_free: assert property (@(posedge clk) disable iff (!rst_n)
    !busy |-> (cmd == C_NOP));
  a_r4_start_on_grant: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(busy) |-> $past(bus_req && bus_gnt));
  a_r5_precharge_gap: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd == C_REF) |-> (since_pre == PW'(T_RP)));
  a_r6_recovery_hold: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(busy) |-> (since_ref >= RW'(T_RFC)));
  a_r9_cke_fall_on_ref: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(cke) |-> (cmd == C_REF));
  a_r9_dll_off_entry: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(dll_en) |-> (!cke && cmd == C_REF));
  a_r10_sr_no_cmd: assert property (@(posedge clk) disable iff (!rst_n)
    (!cke && $past(!cke)) |-> (cmd == C_NOP && busy));
  a_r10_dll_on_exit: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(dll_en) |-> cke);
endmodule

bind refresh_sequencer refresh_sequencer_chk #(
  .T_RP     (T_RP),
  .T_RFC    (T_RFC),
  .ADDR_W   (ADDR_W),
  .PALL_BIT (PALL_BIT)
) u_chk (
  .clk     (clk),
  .rst_n   (rst_n),
  .bus_gnt (bus_gnt),
  .bus_req (bus_req),
  .busy    (busy),
  .cmd     (cmd),
  .cke     (cke),
  .addr    (addr),
  .dll_en  (dll_en)
);

// File: tb/refresh_sequencer_test.sv
module refresh_sequencer_test;
  localparam int CLK_PERIOD = 10;
  localparam int INTERVAL   = 40;
  localparam int TRP        = 3;
  localparam int TRFC       = 5;
  localparam int AW         = 14;
  localparam int PALL       = 10;
  localparam logic [AW-1:0] PALL_ADDR = AW'(1) << PALL;

  // Vector: {sleep, grant delay[3:0], expected cke on the REFRESH}
  localparam int NV = 4;
  localparam logic [5:0] VEC [NV] = '{
    {1'b0, 4'd0, 1'b1},
    {1'b0, 4'd3, 1'b1},
    {1'b1, 4'd0, 1'b0},
    {1'b1, 4'd2, 1'b0}
  };

  logic clk = 1'b0;
  logic rst_n, sleep_req, wake_req, bus_gnt;
  logic bus_req, busy, cke, dll_en;
  logic [2:0] cmd;
  logic [AW-1:0] addr;

  int n_chk = 0;
  int n_bad = 0;
  bit done  = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  refresh_sequencer #(
    .REF_INTERVAL (INTERVAL),
    .T_RP         (TRP),
    .T_RFC        (TRFC),
    .ADDR_W       (AW),
    .PALL_BIT     (PALL)
  ) uut (
    .clk       (clk),
    .rst_n     (rst_n),
    .sleep_req (sleep_req),
    .wake_req  (wake_req),
    .bus_gnt   (bus_gnt),
    .bus_req   (bus_req),
    .busy      (busy),
    .cmd       (cmd),
    .cke       (cke),
    .addr      (addr),
    .dll_en    (dll_en)
  );

  task automatic check(input bit ok, input string tag, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
    end
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1'b1;
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  endtask

  // Advance until cmd is not NOP; returns the number of negedges taken.
  task automatic until_cmd(output int k);
    k = 0;
    do begin
      @(negedge clk);
      k++;
    end while (cmd == 3'd0 && k < 200);
  endtask

  task automatic until_free(output int k);
    k = 0;
    do begin
      @(negedge clk);
      k++;
    end while (busy && k < 200);
  endtask

  task automatic until_req();
    for (int g = 0; g < 400 && !bus_req; g++) @(negedge clk);
  endtask

  initial begin
    #(CLK_PERIOD * 150000);
    n_chk++;
    n_bad++;
    $display("FAIL watchdog: actual %0d expected %0d", 1, 0);
    finish_run();
  end

  initial begin
    int k;
    int seen;
    rst_n = 1'b0; sleep_req = 1'b0; wake_req = 1'b0; bus_gnt = 1'b0;
    repeat (3) @(negedge clk);
    // R1 reset state
    check(cke == 1'b1,    "R1 cke",     cke, 1);
    check(dll_en == 1'b1, "R1 dll_en",  dll_en, 1);
    check(busy == 1'b0,   "R1 busy",    busy, 0);
    check(bus_req == 1'b0,"R1 bus_req", bus_req, 0);
    check(cmd == 3'd0,    "R1 cmd",     cmd, 0);
    check(addr == '0,     "R1 addr",    int'(addr), 0);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);

    // R11: wake outside self refresh does nothing
    wake_req = 1'b1;
    @(negedge clk);
    wake_req = 1'b0;
    @(negedge clk);
    check(cke == 1'b1 && busy == 1'b0 && bus_req == 1'b0, "R11 wake ignored",
          {cke, busy, bus_req}, 3'b100);

    // Table walk: refresh and self-refresh sequences with grant delays
    for (int v = 0; v < NV; v++) begin
      bit        sl;
      int        dly;
      bit        ecke;
      sl   = VEC[v][5];
      dly  = int'(VEC[v][4:1]);
      ecke = VEC[v][0];
      if (sl) sleep_req = 1'b1;
      until_req();
      check(bus_req == 1'b1, "R4 request raised", bus_req, 1);
      for (int d = 0; d < dly; d++) begin
        @(negedge clk);
        check(busy == 1'b0 && cmd == 3'd0, "R4 wait for grant", {busy, cmd}, 0);
      end
      bus_gnt = 1'b1;
      @(negedge clk);
      bus_gnt = 1'b0;
      check(busy == 1'b1,    "R4 busy after grant", busy, 1);
      check(cmd == 3'd1,     "R2 precharge code", cmd, 1);
      check(addr == PALL_ADDR, "R2 precharge-all address", int'(addr), int'(PALL_ADDR));
      until_cmd(k);
      check(k == TRP,        "R5 precharge to refresh", k, TRP);
      check(cmd == 3'd2,     "R2 refresh code", cmd, 2);
      check(addr == '0,      "R2 refresh address", int'(addr), 0);
      check(cke == ecke,     "R9 cke on refresh", cke, ecke);
      if (!sl) begin
        until_free(k);
        check(k == TRFC,     "R6 refresh recovery", k, TRFC);
      end else begin
        check(dll_en == 1'b0, "R9 dll off at entry", dll_en, 0);
        sleep_req = 1'b0;
        for (int h = 0; h < 6; h++) begin
          @(negedge clk);
          check(cke == 1'b0 && cmd == 3'd0 && busy == 1'b1, "R10 self refresh hold",
                {cke, cmd, busy}, 4'b0001);
        end
        wake_req = 1'b1;
        @(negedge clk);
        wake_req = 1'b0;
        check(cke == 1'b1,    "R10 cke on wake", cke, 1);
        check(dll_en == 1'b1, "R10 dll on wake", dll_en, 1);
        until_free(k);
        check(k == TRFC,      "R10 exit recovery", k, TRFC);
      end
      repeat (2) @(negedge clk);
    end

    // R3: refresh spacing with grant held
    bus_gnt = 1'b1;
    do begin @(negedge clk); end while (!(cmd == 3'd2));
    k = 0;
    do begin @(negedge clk); k++; end while (!(cmd == 3'd2) && k < 400);
    check(k == INTERVAL, "R3 refresh period", k, INTERVAL);
    until_free(k);
    bus_gnt = 1'b0;

    // R7: several periods missed, only one refresh remembered
    until_req();
    repeat (2 * INTERVAL + 2) @(negedge clk);
    bus_gnt = 1'b1;
    seen = 0;
    for (int c = 0; c < 20; c++) begin
      @(negedge clk);
      if (cmd == 3'd2) seen++;
    end
    check(seen == 1, "R7 single refresh", seen, 1);
    check(bus_req == 1'b0 && busy == 1'b0, "R7 nothing left", {bus_req, busy}, 0);
    bus_gnt = 1'b0;

    // R8: refresh served before a waiting sleep request
    sleep_req = 1'b1;
    repeat (INTERVAL + 2) @(negedge clk);
    bus_gnt = 1'b1;
    do begin @(negedge clk); end while (!(cmd == 3'd2));
    check(cke == 1'b1, "R8 refresh first", cke, 1);
    do begin @(negedge clk); end while (!(cmd == 3'd2));
    check(cke == 1'b0, "R8 sleep second", cke, 0);
    bus_gnt = 1'b0;
    repeat (3) @(negedge clk);
    check(cke == 1'b0 && cmd == 3'd0, "R10 sleep_req level ignored in hold",
          {cke, cmd}, 0);

    // R1: reset during self refresh
    rst_n = 1'b0;
    #1;
    check(cke == 1'b1 && dll_en == 1'b1 && busy == 1'b0, "R1 reset in self refresh",
          {cke, dll_en, busy}, 3'b110);
    sleep_req = 1'b0;
    @(negedge clk);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);

    finish_run();
  end
endmodule